// File: doc/BRIEF.md
# Run-Length-Limited (2,7) Sector Header Write Encoder

This block produces the serial write stream that opens a disk sector. After a start request it sends a run of gap fill bytes, then a programmable run of preamble bytes, then one sync byte and one address-mark byte, and then the sector data bytes fetched from a host through a request/valid handshake. Every byte, fixed or supplied, enters a single (2,7) run-length-limited encoder. The encoder reads the bytes as one continuous bit stream, most significant bit first, so a code word may begin in one byte and end in the next.

The encoder sends one code bit per clock cycle on `wr_pulse`, and a code 1 means one flux-transition pulse. Each input bit yields two code bits. Leftover bits at the end of the stream are zero-padded up to a whole code word. The encoder asks for the next byte well before its bit buffer runs dry. If a host is late enough that the stream has to stop, a sticky underflow flag is set.

Top module: `rll27_sector_writer`

## Requirements
- R1: While reset is held and after it is released, `wr_pulse`, `busy`, `data_req` and `underflow` are all 0.
- R2: The stream begins with `gap_count` copies of the fill byte 0x33. Each copy encodes to 0000100000001000: one pulse, then seven empty periods.
- R3: After the gap come `pre_count` copies of 0xFF. Each copy encodes to 1000100010001000.
- R4: After the preamble comes the sync byte 0x62, which encodes to 0010000001000100.
- R5: After sync comes the mark byte 0xFE, which encodes to 1000100010000100.
- R6: The bytes are parsed MSB-first as one continuous stream, using the table 11→1000, 10→0100, 000→000100, 010→100100, 011→001000, 0011→00001000, 0010→00100100. Code words may span byte boundaries. The first code bit shows on `wr_pulse` in the cycle after the second clock edge that follows the edge accepting `start`. After that, one bit shows per cycle.
- R7: Bits left over at the end of the stream that do not form a whole code word are padded with zeros until they match one. For example, a final leftover 01 is sent as 100100.
- R8: Inside an unbroken stream, every pair of successive pulses has at least 2 and at most 7 empty periods between them.
- R9: A data byte is taken on a clock edge where both `data_req` and `data_valid` are 1, and `data_req` stays high until the byte is taken. A host that answers each request one cycle late still sees an exact stream and no underflow.
- R10: If the encoder needs a code word while data bits are missing, `underflow` becomes 1. It stays 1 until the next accepted `start`, and the stream resumes once data arrives.
- R11: A `start` pulse while `busy` is 1 is ignored. The running sector keeps the counts latched when it was accepted.
- R12: A gap count, preamble count or data count of 0 skips that field. `busy` stays high for one cycle after the cycle that shows the last code bit, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sector when idle |
| gap_count | input | CW | Number of gap fill bytes |
| pre_count | input | CW | Number of preamble bytes |
| data_count | input | DW | Number of sector data bytes |
| data_req | output | 1 | Encoder wants the next data byte |
| data_valid | input | 1 | Host presents a data byte |
| data_byte | input | 8 | Data byte from the host |
| wr_pulse | output | 1 | Serial code bit, 1 = write pulse |
| busy | output | 1 | A sector is being produced |
| underflow | output | 1 | Sticky flag: data arrived too late |

## Verification
Two things can happen in the same cycle. At a word boundary, the encoder removes the bits of the word it is parsing, and in that same cycle a newly accepted byte is merged behind the bits that remain. This is provoked with a host that answers at once and with a host that answers one cycle late, using random data. Those two timings move the byte arrival onto and off the parse cycle. The result is judged by comparing every bit of the output against a bench-side parse of the same byte sequence.

// File: rtl/rll_hdr_pkg.sv
// Package: shared constants and the phase type for the sector header writer.
// Assumes byte-wide input and a (2,7) code whose words consume at most 4 bits.
package rll_hdr_pkg;

    localparam int BYTE_W  = 8;               // input byte width
    localparam int MAX_IN  = 4;               // longest input word of the code
    localparam int BUF_W   = BYTE_W + MAX_IN; // input bit buffer depth
    localparam int CODE_W  = 2 * MAX_IN;      // longest code word

    localparam logic [BYTE_W-1:0] FILL_GAP  = 8'h33;
    localparam logic [BYTE_W-1:0] FILL_PRE  = 8'hFF;
    localparam logic [BYTE_W-1:0] SYNC_VAL  = 8'h62;
    localparam logic [BYTE_W-1:0] MARK_VAL  = 8'hFE;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_PRE,
        PH_SYNC,
        PH_MARK,
        PH_DATA,
        PH_DONE
    } hdr_phase_t;

endpackage

// File: rtl/rll27_word_map.sv
// Module: rll27_word_map
// Maps the head of the input bit buffer to one (2,7) code word.
// Assumes bits past the valid part of the buffer are zero, so a short
// tail reads as zero-padded. Code is left-aligned; its length is 2*in_len.
module rll27_word_map
    import rll_hdr_pkg::*;
(
    input  logic [MAX_IN-1:0] head,
    output logic [2:0]        in_len,
    output logic [CODE_W-1:0] code
);

    // Prefix decode of the code table, most significant bit first.
    always_comb begin
        if (head[3]) begin
            in_len = 3'd2;
            code   = head[2] ? 8'b1000_0000 : 8'b0100_0000;
        end else if (head[2]) begin
            in_len = 3'd3;
            code   = head[1] ? 8'b0010_0000 : 8'b1001_0000;
        end else if (!head[1]) begin
            in_len = 3'd3;
            code   = 8'b0001_0000;
        end else begin
            in_len = 3'd4;
            code   = head[0] ? 8'b0000_1000 : 8'b0010_0100;
        end
    end

endmodule

// File: rtl/rll27_serializer.sv
// Module: rll27_serializer
// Keeps an input bit buffer, parses code words from it when the output
// register is about to empty, and shifts one code bit per cycle.
// Assumes the byte source honours in_ready; flush means no more bytes.
module rll27_serializer
    import rll_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              flush,
    output logic              wr_pulse,
    output logic              idle,
    output logic              starve
);

    localparam int CNT_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0]  ibuf_q, shifted, merged;
    logic [CNT_W-1:0]  ibits_q, rem, len_w;
    logic [CODE_W-1:0] oreg_q, code;
    logic [3:0]        ocnt_q;
    logic [2:0]        in_len;
    logic              slot_free, fits, take, accept;

    rll27_word_map u_map (
        .head   (ibuf_q[BUF_W-1 -: MAX_IN]),
        .in_len (in_len),
        .code   (code)
    );

    // Decide whether a word is parsed this cycle and what the buffer keeps.
    always_comb begin
        len_w     = CNT_W'(in_len);
        slot_free = (ocnt_q <= 4'd1);
        fits      = (len_w <= ibits_q);
        take      = slot_free && (fits || (flush && ibits_q != '0));
        rem       = take ? (fits ? ibits_q - len_w : '0) : ibits_q;
        shifted   = take ? (ibuf_q << in_len) : ibuf_q;
        in_ready  = (rem <= CNT_W'(MAX_IN));
        accept    = in_valid && in_ready;
        merged    = shifted | (accept ? ({in_byte, {MAX_IN{1'b0}}} >> rem) : '0);
    end

    // Buffer, output shift register and its bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf_q  <= '0;
            ibits_q <= '0;
            oreg_q  <= '0;
            ocnt_q  <= '0;
        end else begin
            ibuf_q  <= merged;
            ibits_q <= rem + (accept ? CNT_W'(BYTE_W) : '0);
            if (take) begin
                oreg_q <= code;
                ocnt_q <= {in_len, 1'b0};
            end else begin
                oreg_q <= oreg_q << 1;
                if (ocnt_q != 4'd0)
                    ocnt_q <= ocnt_q - 4'd1;
            end
        end
    end

    assign wr_pulse = oreg_q[CODE_W-1];
    assign idle     = (ocnt_q == 4'd0) && (ibits_q == '0);
    assign starve   = (ocnt_q == 4'd1) && !take && !flush;

    // Length of the current run of empty code periods, for the run checks.
    logic [3:0] zrun_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun_q <= '0;
        else if (wr_pulse || ocnt_q == 4'd0)
            zrun_q <= '0;
        else if (zrun_q != 4'hF)
            zrun_q <= zrun_q + 4'd1;
    end

    assert_min_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (!$past(wr_pulse) && !$past(wr_pulse, 2)));

    assert_max_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q <= 4'd7);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ibits_q <= CNT_W'(BUF_W));

endmodule

// File: rtl/hdr_sequencer.sv
// Module: hdr_sequencer
// Walks the sector fields (gap, preamble, sync, mark, data) and offers one
// byte at a time to the serializer. Counts are latched at start.
// Assumes the serializer drains and reports idle after flush.
module hdr_sequencer
    import rll_hdr_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     gap_count,
    input  logic [CW-1:0]     pre_count,
    input  logic [DW-1:0]     data_count,
    input  logic              enc_ready,
    input  logic              enc_idle,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              src_valid,
    output logic [BYTE_W-1:0] src_byte,
    output logic              data_req,
    output logic              flush,
    output logic              busy,
    output logic              start_acc
);

    localparam int LW = (CW > DW) ? CW : DW;

    hdr_phase_t      phase_q, after_ph, first_ph;
    logic [LW-1:0]   left_q, after_left, first_left;
    logic [CW-1:0]   pre_q;
    logic [DW-1:0]   data_q;
    logic            accept, last;

    // Field that follows the current one, skipping empty fields.
    always_comb begin
        after_ph   = phase_q;
        after_left = '0;
        case (phase_q)
            PH_GAP:  begin
                after_ph   = (pre_q != '0) ? PH_PRE : PH_SYNC;
                after_left = LW'(pre_q);
            end
            PH_PRE:  after_ph = PH_SYNC;
            PH_SYNC: after_ph = PH_MARK;
            PH_MARK: begin
                after_ph   = (data_q != '0) ? PH_DATA : PH_DONE;
                after_left = LW'(data_q);
            end
            PH_DATA: after_ph = PH_DONE;
            default: after_ph = phase_q;
        endcase
        if (gap_count != '0) begin
            first_ph   = PH_GAP;
            first_left = LW'(gap_count);
        end else begin
            first_ph   = (pre_count != '0) ? PH_PRE : PH_SYNC;
            first_left = LW'(pre_count);
        end
    end

    // Byte offered to the serializer in each field.
    always_comb begin
        src_valid = 1'b1;
        case (phase_q)
            PH_GAP:  src_byte = FILL_GAP;
            PH_PRE:  src_byte = FILL_PRE;
            PH_SYNC: src_byte = SYNC_VAL;
            PH_MARK: src_byte = MARK_VAL;
            PH_DATA: begin
                src_byte  = data_byte;
                src_valid = data_valid;
            end
            default: begin
                src_byte  = '0;
                src_valid = 1'b0;
            end
        endcase
    end

    assign start_acc = start && (phase_q == PH_IDLE);
    assign accept    = src_valid && enc_ready;
    assign last      = (phase_q == PH_GAP || phase_q == PH_PRE || phase_q == PH_DATA)
                       ? (left_q == LW'(1)) : 1'b1;
    assign data_req  = (phase_q == PH_DATA) && enc_ready;
    assign flush     = (phase_q == PH_DONE);
    assign busy      = (phase_q != PH_IDLE);

    // Field state, remaining byte count and latched counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            pre_q   <= '0;
            data_q  <= '0;
        end else if (start_acc) begin
            phase_q <= first_ph;
            left_q  <= first_left;
            pre_q   <= pre_count;
            data_q  <= data_count;
        end else if (phase_q == PH_DONE && enc_idle) begin
            phase_q <= PH_IDLE;
        end else if (accept) begin
            if (last) begin
                phase_q <= after_ph;
                left_q  <= after_left;
            end else begin
                left_q  <= left_q - LW'(1);
            end
        end
    end

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && phase_q != PH_IDLE) |=> ($stable(pre_q) && $stable(data_q)));

endmodule

// File: rtl/rll27_sector_writer.sv
// Module: rll27_sector_writer (top)
// Sector header writer: field sequencer feeding a (2,7) serializer, plus
// the sticky underflow flag. Assumes a host that answers data_req.
module rll27_sector_writer
    import rll_hdr_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] gap_count,
    input  logic [CW-1:0] pre_count,
    input  logic [DW-1:0] data_count,
    output logic          data_req,
    input  logic          data_valid,
    input  logic [7:0]    data_byte,
    output logic          wr_pulse,
    output logic          busy,
    output logic          underflow
);

    logic              src_valid, enc_ready, enc_idle, flush, starve, start_acc;
    logic [BYTE_W-1:0] src_byte;
    logic              uflow_q;

    hdr_sequencer #(.CW(CW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gap_count  (gap_count),
        .pre_count  (pre_count),
        .data_count (data_count),
        .enc_ready  (enc_ready),
        .enc_idle   (enc_idle),
        .data_valid (data_valid),
        .data_byte  (data_byte),
        .src_valid  (src_valid),
        .src_byte   (src_byte),
        .data_req   (data_req),
        .flush      (flush),
        .busy       (busy),
        .start_acc  (start_acc)
    );

    rll27_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (src_valid),
        .in_byte  (src_byte),
        .in_ready (enc_ready),
        .flush    (flush),
        .wr_pulse (wr_pulse),
        .idle     (enc_idle),
        .starve   (starve)
    );

    // Sticky late-data flag, cleared when a new sector starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uflow_q <= 1'b0;
        else if (start_acc)
            uflow_q <= 1'b0;
        else if (starve)
            uflow_q <= 1'b1;
    end

    assign underflow = uflow_q;

    assert_uflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_q && !start_acc) |=> uflow_q);

    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_pulse);

endmodule

// File: tb/rll27_sector_writer_tb_top.sv
`timescale 1ns/1ps
module rll27_sector_writer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] gap_count = '0;
    logic [7:0] pre_count = '0;
    logic [9:0] data_count = '0;
    logic       data_req;
    logic       data_valid = 1'b0;
    logic [7:0] data_byte = '0;
    logic       wr_pulse, busy, underflow;

    always #2 clk = ~clk;   // 250 MHz

    rll27_sector_writer #(.CW(8), .DW(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .gap_count(gap_count), .pre_count(pre_count), .data_count(data_count),
        .data_req(data_req), .data_valid(data_valid), .data_byte(data_byte),
        .wr_pulse(wr_pulse), .busy(busy), .underflow(underflow)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] dbytes [0:63];
    logic       inb    [0:1023];
    logic       expb   [0:2047];
    logic       got    [0:4095];
    int nin, nexp, ngot, accepted;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            inb[nin] = b[k];
            nin++;
        end
    endtask

    function automatic logic gb(input int i);
        return (i < nin) ? inb[i] : 1'b0;
    endfunction

    task automatic emit(input logic [7:0] c, input int len);
        for (int k = 0; k < len; k++) begin
            expb[nexp] = c[7-k];
            nexp++;
        end
    endtask

    // Bench model: field bytes, then table parse with zero padding.
    task automatic build_model(input int g, input int p, input int n);
        int pos;
        nin = 0; nexp = 0; pos = 0;
        for (int i = 0; i < g; i++) push_byte(8'h33);
        for (int i = 0; i < p; i++) push_byte(8'hFF);
        push_byte(8'h62);
        push_byte(8'hFE);
        for (int i = 0; i < n; i++) push_byte(dbytes[i]);
        while (pos < nin) begin
            if (gb(pos)) begin
                emit(gb(pos+1) ? 8'b1000_0000 : 8'b0100_0000, 4); pos += 2;
            end else if (gb(pos+1)) begin
                emit(gb(pos+2) ? 8'b0010_0000 : 8'b1001_0000, 6); pos += 3;
            end else if (!gb(pos+2)) begin
                emit(8'b0001_0000, 6); pos += 3;
            end else begin
                emit(gb(pos+3) ? 8'b0000_1000 : 8'b0010_0100, 8); pos += 4;
            end
        end
    endtask

    function automatic logic [15:0] pack16(input int off);
        logic [15:0] v;
        for (int k = 0; k < 16; k++) v[15-k] = got[off+k];
        return v;
    endfunction

    // mode 0: host answers at once; 1: one cycle late; 2: long stall first.
    task automatic run_sector(input int g, input int p, input int n,
                              input int mode, input bit poke);
        bit rec_done, pending, stalled_once;
        int idx, stall, cyc;
        rec_done = 0; pending = 0; stalled_once = 0;
        idx = 0; stall = 0; cyc = 0; accepted = 0;
        build_model(g, p, n);
        @(negedge clk);
        gap_count = 8'(g); pre_count = 8'(p); data_count = 10'(n); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                @(posedge clk);
                @(posedge clk);
                ngot = 0;
                while (1) begin
                    @(negedge clk);
                    if (!busy || ngot >= 4000) break;
                    got[ngot] = wr_pulse;
                    ngot++;
                end
                rec_done = 1;
            end
            begin
                while (!rec_done) begin
                    @(negedge clk);
                    cyc++;
                    if (poke && cyc == 30) begin
                        start = 1'b1; gap_count = 8'd7; pre_count = 8'd1; data_count = 10'd3;
                    end else if (poke && cyc == 31) begin
                        start = 1'b0;
                    end
                    data_byte = dbytes[idx % 64];
                    case (mode)
                        0: data_valid = 1'b1;
                        1: data_valid = pending;
                        default: begin
                            if (!stalled_once) data_valid = 1'b0;
                            else if (stall > 0) begin data_valid = 1'b0; stall--; end
                            else data_valid = 1'b1;
                        end
                    endcase
                    #0.5;
                    if (data_req && data_valid) begin
                        idx++; accepted++; pending = 0;
                    end else if (data_req) begin
                        pending = 1;
                        if (mode == 2 && !stalled_once) begin
                            stalled_once = 1; stall = 40;
                        end
                    end
                end
                data_valid = 1'b0;
            end
        join
    endtask

    task automatic cmp_stream(input string tag);
        int mism = 0;
        for (int i = 0; i < nexp; i++) if (got[i] !== expb[i]) mism++;
        chk({tag, " stream mismatches"}, mism, 0);
    endtask

    task automatic check_runs(input string tag);
        int last = -1, bad = 0;
        for (int i = 0; i < ngot; i++) begin
            if (got[i]) begin
                if (last >= 0 && ((i - last - 1) < 2 || (i - last - 1) > 7)) bad++;
                last = i;
            end
        end
        chk({tag, " run-length violations"}, bad, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 wr_pulse in reset", wr_pulse, 0);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 data_req after reset", data_req, 0);
        chk("R1 underflow after reset", underflow, 0);
    endtask

    task automatic t_fixed_fields;
        run_sector(0, 0, 0, 0, 0);
        chk("R4 sync code", pack16(0), 16'b0010000001000100);
        chk("R5 mark code", pack16(16), 16'b1000100010000100);
        chk("R12 length with empty fields", ngot, 33);
    endtask

    task automatic t_gap;
        run_sector(3, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++)
            chk("R2 gap code", pack16(16*i), 16'b0000100000001000);
        cmp_stream("R2");
    endtask

    task automatic t_preamble;
        run_sector(1, 4, 0, 0, 0);
        for (int i = 0; i < 4; i++)
            chk("R3 preamble code", pack16(16 + 16*i), 16'b1000100010001000);
        chk("R4 sync after preamble", pack16(80), 16'b0010000001000100);
    endtask

    task automatic t_span;
        dbytes[0] = 8'h01; dbytes[1] = 8'h80; dbytes[2] = 8'h5A; dbytes[3] = 8'hC3;
        dbytes[4] = 8'h07;
        run_sector(1, 2, 5, 0, 0);
        cmp_stream("R6 boundary-spanning data");
        chk("R12 busy falls one cycle after last bit", ngot, nexp + 1);
    endtask

    task automatic t_padding;
        dbytes[0] = 8'h01;
        run_sector(0, 0, 1, 0, 0);
        chk("R7 padded length", ngot, 51);
        chk("R7 padded tail 010", {got[44], got[45], got[46], got[47], got[48], got[49]},
            6'b100100);
        cmp_stream("R7");
    endtask

    task automatic t_random;
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < 32; i++) dbytes[i] = 8'($urandom_range(0, 255));
            run_sector(s, 3, 32, 0, 0);
            cmp_stream("R6 random data");
            check_runs("R8");
        end
    endtask

    task automatic t_late_host;
        for (int i = 0; i < 24; i++) dbytes[i] = 8'($urandom_range(0, 255));
        run_sector(2, 2, 24, 1, 0);
        cmp_stream("R9 late host");
        chk("R9 bytes taken", accepted, 24);
        chk("R9 no underflow", underflow, 0);
        check_runs("R8 late host");
    endtask

    task automatic t_underflow;
        int ones_g = 0, ones_e = 0;
        for (int i = 0; i < 8; i++) dbytes[i] = 8'($urandom_range(0, 255));
        run_sector(0, 1, 8, 2, 0);
        for (int i = 0; i < ngot; i++) ones_g += got[i];
        for (int i = 0; i < nexp; i++) ones_e += expb[i];
        chk("R10 underflow set", underflow, 1);
        chk("R10 pulses after resume", ones_g, ones_e);
        run_sector(0, 0, 2, 0, 0);
        chk("R10 underflow cleared by start", underflow, 0);
    endtask

    task automatic t_start_ignored;
        for (int i = 0; i < 4; i++) dbytes[i] = 8'($urandom_range(0, 255));
        run_sector(2, 2, 4, 0, 1);
        cmp_stream("R11 start while busy");
        chk("R11 length unchanged", ngot, nexp + 1);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R12 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        t_reset();
        t_fixed_fields();
        t_gap();
        t_preamble();
        t_span();
        t_padding();
        t_random();
        t_late_host();
        t_underflow();
        t_start_ignored();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule